// File: doc/BRIEF.md
# Single-Lane Vector Store Sequencer

This block executes a vector "store one lane" instruction. It takes a 32-bit instruction word together with the base address value and an optional post-index register value. It checks the encoding, reads the source vector registers through a single read port, and writes one element from the chosen lane of each register. A structure spans one to four consecutive registers, and the register number wraps past 31 back to 0. Each element goes out as one memory beat. The beat address starts at the base and advances by the element size after each element.

The post-index form adds one more step after the last beat is accepted: a single writeback pulse. It adds either the offset register value or the total number of bytes stored to the base. The destination is either the stack pointer or a general register. A reserved encoding raises a one-cycle fault and no traffic at all. So does a stack-pointer base that is not 16-byte aligned. While an instruction is in flight, the block ignores any new instruction.

Top module: `lane_store_seq`

## Requirements
- R1: An instruction is undefined if any of these holds: bit 31 is not 0; bits 29:24 are not 001101; the load bit 22 is 1; or bit 23 is 0 (no-offset class) and bits 20:16 are not all zero.
- R2: The number of registers stored is 1 + {bits[13], bit[21]}, so 1 to 4. Register k of the structure is (bits[4:0] + k) mod 32.
- R3: The element scale is bits[15:14]. With scale 0, the element is 1 byte and the lane is {bit30, bit12, bits[11:10]}. With scale 1, the element is 2 bytes and the lane is {bit30, bit12, bit11}; bit 10 set is undefined.
- R4: With scale 2, bit 11 set is undefined. If bit 10 is 0, the element is 4 bytes and the lane is {bit30, bit12}. If bit 10 is 1, the element is 8 bytes and the lane is bit30; in that case bit 12 set is undefined.
- R5: Scale 3 is undefined.
- R6: Each beat carries the lane bytes of the element at the bottom of `mem_data_o`, with all higher bytes zero. `mem_bytes_o` holds the element size in bytes (1, 2, 4 or 8).
- R7: Beat k has address base + k × element bytes and reads register (Rt + k) mod 32.
- R8: In the post-index class (bit 23 = 1), one `wb_valid_o` pulse follows the final accepted beat. Its value is base + Rm value when bits[20:16] ≠ 31, and base + total bytes stored otherwise. `wb_sp_o` = 1 when bits[9:5] = 31, and `wb_reg_o` = bits[9:5]. The no-offset class produces no writeback.
- R9: When bits[9:5] = 31, the base is the stack pointer. A base with any of bits 3:0 set is then a fault.
- R10: An undefined or misaligned instruction raises `fault_o` for exactly one cycle, in the cycle after it is accepted. It produces no beat and no writeback.
- R11: A beat holds its address, data and size until `mem_ready_i` is high. An instruction presented while `busy_o` is high is ignored.
- R12: After reset, `mem_valid_o`, `wb_valid_o`, `fault_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction present |
| insn_i | input | 32 | Instruction word |
| base_i | input | 64 | Base register value (stack pointer when bits[9:5] = 31) |
| offs_reg_i | input | 64 | Post-index register value |
| vrd_idx_o | output | 5 | Vector register read index |
| vrd_data_i | input | 128 | Vector register read data |
| mem_valid_o | output | 1 | Memory beat valid |
| mem_ready_i | input | 1 | Memory beat accepted |
| mem_addr_o | output | 64 | Beat byte address |
| mem_data_o | output | 64 | Beat data, element in low bytes |
| mem_bytes_o | output | 4 | Beat size in bytes |
| wb_valid_o | output | 1 | Base writeback pulse |
| wb_sp_o | output | 1 | Writeback targets the stack pointer |
| wb_reg_o | output | 5 | Writeback general register number |
| wb_data_o | output | 64 | New base value |
| fault_o | output | 1 | Undefined encoding or misaligned stack pointer |
| busy_o | output | 1 | Instruction in flight |

## Verification
Random instruction words cover every scale, size, S and Q combination. These show whether the lane index and element width come from the right bits, and whether each reserved combination is caught. Directed cases separate the register-offset writeback from the byte-count writeback, using a start register of 30 so the wrap past 31 shows up in the beat order. They also try stack-pointer bases that are aligned and misaligned, and set nonzero bits 20:16 in the no-offset form. Throttling `mem_ready_i` shows that beats hold steady while stalled. An instruction injected mid-transfer shows that it leaves the running sequence unchanged.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned VLEN      = 128;
  localparam int unsigned DLEN      = 64;
  localparam int unsigned RIDX_W    = 5;
  localparam int unsigned SP_ALIGN  = 4;

  typedef struct packed {
    logic              undef;
    logic              post;
    logic [1:0]        last;   // registers in structure minus one
    logic [1:0]        lsz;    // log2 element bytes
    logic [3:0]        lane;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rm;
  } dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_WB} st_e;
endpackage

// File: rtl/lss_decode.sv
module lss_decode
  import lss_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  logic       q, s;
  logic [1:0] sz;
  logic [2:0] op;
  logic       bad;

  assign q  = insn_i[30];
  assign s  = insn_i[12];
  assign sz = insn_i[11:10];
  assign op = insn_i[15:13];

  always_comb begin
    bad = insn_i[31] | (insn_i[29:24] != 6'b001101) | insn_i[22]
        | (!insn_i[23] && insn_i[20:16] != 5'd0);
    dec_o.lsz  = 2'd0;
    dec_o.lane = 4'd0;
    unique case (op[2:1])
      2'd0: begin
        dec_o.lsz  = 2'd0;
        dec_o.lane = {q, s, sz};
      end
      2'd1: begin
        bad        = bad | sz[0];
        dec_o.lsz  = 2'd1;
        dec_o.lane = {1'b0, q, s, sz[1]};
      end
      2'd2: begin
        bad = bad | sz[1];
        if (!sz[0]) begin
          dec_o.lsz  = 2'd2;
          dec_o.lane = {2'b0, q, s};
        end else begin
          bad        = bad | s;
          dec_o.lsz  = 2'd3;
          dec_o.lane = {3'b0, q};
        end
      end
      default: bad = 1'b1; // replicate form has no store
    endcase
    dec_o.undef = bad;
    dec_o.post  = insn_i[23];
    dec_o.last  = {op[0], insn_i[21]};
    dec_o.rt    = insn_i[4:0];
    dec_o.rn    = insn_i[9:5];
    dec_o.rm    = insn_i[20:16];
  end
endmodule

// File: rtl/lss_lane_pick.sv
module lss_lane_pick #(
  parameter int unsigned VW = 128,
  parameter int unsigned DW = 64
) (
  input  logic [VW-1:0] vreg_i,
  input  logic [3:0]    lane_i,
  input  logic [1:0]    lsz_i,
  output logic [DW-1:0] data_o,
  output logic [3:0]    bytes_o
);
  localparam int unsigned NB = DW / 8;

  logic [6:0]    byte_off;
  logic [9:0]    bit_off;
  logic [VW-1:0] shifted;

  assign byte_off = {3'b0, lane_i} << lsz_i;
  assign bit_off  = {byte_off, 3'b000};
  assign shifted  = vreg_i >> bit_off;
  assign bytes_o  = 4'b0001 << lsz_i;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [3:0] BIDX = 4'(b);
    assign data_o[8*b +: 8] = (BIDX < bytes_o) ? shifted[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/lane_store_seq.sv
module lane_store_seq
  import lss_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   offs_reg_i,
  output logic [RIDX_W-1:0] vrd_idx_o,
  input  logic [VLEN-1:0]   vrd_data_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [DLEN-1:0]   mem_data_o,
  output logic [3:0]        mem_bytes_o,
  output logic              wb_valid_o,
  output logic              wb_sp_o,
  output logic [RIDX_W-1:0] wb_reg_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              fault_o,
  output logic              busy_o
);
  localparam logic [RIDX_W-1:0] REG_SP = '1;

  dec_t              dec, dec_q;
  st_e               st_q;
  logic [XLEN-1:0]   base_q, rmv_q, offs_q;
  logic [RIDX_W-1:0] t_q;
  logic [1:0]        cnt_q;
  logic              fault_q;
  logic              accept, misal, bad, fire;

  lss_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  lss_lane_pick #(.VW(VLEN), .DW(DLEN)) u_pick (
    .vreg_i (vrd_data_i),
    .lane_i (dec_q.lane),
    .lsz_i  (dec_q.lsz),
    .data_o (mem_data_o),
    .bytes_o(mem_bytes_o)
  );

  assign accept = insn_valid_i && (st_q == ST_IDLE);
  assign misal  = (dec.rn == REG_SP) && (base_i[SP_ALIGN-1:0] != '0);
  assign bad    = dec.undef | misal;
  assign fire   = mem_valid_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dec_q   <= '0;
      base_q  <= '0;
      rmv_q   <= '0;
      offs_q  <= '0;
      t_q     <= '0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= accept && bad;
      unique case (st_q)
        ST_IDLE: if (accept && !bad) begin
          st_q   <= ST_BEAT;
          dec_q  <= dec;
          base_q <= base_i;
          rmv_q  <= offs_reg_i;
          offs_q <= '0;
          t_q    <= dec.rt;
          cnt_q  <= '0;
        end
        ST_BEAT: if (fire) begin
          offs_q <= offs_q + {{(XLEN-4){1'b0}}, mem_bytes_o};
          t_q    <= t_q + 1'b1;   // wraps mod 32
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == dec_q.last) st_q <= dec_q.post ? ST_WB : ST_IDLE;
        end
        ST_WB:   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign vrd_idx_o   = t_q;
  assign mem_valid_o = (st_q == ST_BEAT);
  assign mem_addr_o  = base_q + offs_q;
  assign wb_valid_o  = (st_q == ST_WB);
  assign wb_sp_o     = (dec_q.rn == REG_SP);
  assign wb_reg_o    = dec_q.rn;
  assign wb_data_o   = base_q + ((dec_q.rm == REG_SP) ? offs_q : rmv_q);
  assign fault_o     = fault_q;
  assign busy_o      = (st_q != ST_IDLE);
endmodule

// File: rtl/lss_checker.sv
module lss_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  vrd_idx_o,
  input logic        mem_valid_o,
  input logic        mem_ready_i,
  input logic [63:0] mem_addr_o,
  input logic [63:0] mem_data_o,
  input logic [3:0]  mem_bytes_o,
  input logic        wb_valid_o,
  input logic        fault_o,
  input logic        busy_o
);
  assert_fault_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!mem_valid_o && !wb_valid_o && !busy_o));

  assert_fault_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  assert_beat_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o) && $stable(mem_bytes_o)));

  assert_size_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ($countones(mem_bytes_o) == 1 && !mem_bytes_o[3:0] == 1'b0));

  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i) |=>
      (!mem_valid_o || mem_addr_o == $past(mem_addr_o) + {60'd0, $past(mem_bytes_o)}));

  assert_reg_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i) |=> (!mem_valid_o || vrd_idx_o == $past(vrd_idx_o) + 5'd1));

  assert_wb_after_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> ($past(mem_valid_o && mem_ready_i) && $fell(mem_valid_o)));

  assert_wb_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> (!wb_valid_o && !busy_o));
endmodule

bind lane_store_seq lss_checker u_lss_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vrd_idx_o  (vrd_idx_o),
  .mem_valid_o(mem_valid_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .mem_bytes_o(mem_bytes_o),
  .wb_valid_o (wb_valid_o),
  .fault_o    (fault_o),
  .busy_o     (busy_o)
);

// File: tb/tb_lane_store_seq.sv
module tb_lane_store_seq;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         insn_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [63:0]  base_v = '0, rm_v = '0;
  logic [4:0]   vrd_idx;
  logic [127:0] vrd_data;
  logic         mem_valid, mem_ready = 1'b0;
  logic [63:0]  mem_addr, mem_data;
  logic [3:0]   mem_bytes;
  logic         wb_valid, wb_sp;
  logic [4:0]   wb_reg;
  logic [63:0]  wb_data;
  logic         fault, busy;
  logic [127:0] vregs [32];
  int           n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign vrd_data = vregs[vrd_idx];

  lane_store_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .insn_valid_i(insn_valid), .insn_i(insn),
    .base_i(base_v), .offs_reg_i(rm_v), .vrd_idx_o(vrd_idx), .vrd_data_i(vrd_data),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .mem_bytes_o(mem_bytes), .wb_valid_o(wb_valid),
    .wb_sp_o(wb_sp), .wb_reg_o(wb_reg), .wb_data_o(wb_data), .fault_o(fault),
    .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference decode from the requirements
  function automatic void ref_dec(input logic [31:0] w, input logic [63:0] base,
                                  output bit bad, output int nregs, output int eb,
                                  output int lane);
    logic q, s; logic [1:0] sz, sc;
    q = w[30]; s = w[12]; sz = w[11:10]; sc = w[15:14];
    bad = w[31] || w[29:24] != 6'b001101 || w[22] || (!w[23] && w[20:16] != 0);
    nregs = 1 + int'({w[13], w[21]});
    eb = 1; lane = 0;
    case (sc)
      2'd0: begin eb = 1; lane = int'({q, s, sz}); end
      2'd1: begin eb = 2; lane = int'({q, s, sz[1]}); if (sz[0]) bad = 1; end
      2'd2: begin
        if (sz[1]) bad = 1;
        if (!sz[0]) begin eb = 4; lane = int'({q, s}); end
        else begin eb = 8; lane = int'(q); if (s) bad = 1; end
      end
      default: bad = 1;
    endcase
    if (w[9:5] == 5'd31 && base[3:0] != 0) bad = 1;
  endfunction

  function automatic logic [31:0] gen_insn();
    logic [31:0] w;
    w = $urandom;
    w[31] = 1'b0; w[29:24] = 6'b001101; w[22] = 1'b0;
    if (!w[23]) w[20:16] = '0;
    if ($urandom % 4 == 0) w[9:5] = 5'd31;
    if ($urandom % 4 == 0) w[20:16] = w[23] ? 5'd31 : 5'd0;
    if ($urandom % 12 == 0) w[31] = 1'b1;
    return w;
  endfunction

  task automatic run(input logic [31:0] w, input logic [63:0] base, input logic [63:0] rmv,
                     input int rdy_pct, input bit poke, input string tag);
    bit bad; int n, eb, lane, k, cyc;
    logic [127:0] expd, mask;
    logic [63:0] expw;
    ref_dec(w, base, bad, n, eb, lane);
    @(negedge clk);
    insn_valid = 1'b1; insn = w; base_v = base; rm_v = rmv;
    @(negedge clk);
    insn_valid = 1'b0;
    chk(fault === bad, tag, "fault flag", 128'(fault), 128'(bad));
    if (bad) begin
      chk(!mem_valid && !wb_valid, "R10", "traffic on fault", 128'({mem_valid, wb_valid}), 0);
      @(negedge clk);
      chk(fault === 1'b0 && !busy, "R10", "fault width", 128'({fault, busy}), 0);
      return;
    end
    mask = (eb == 8) ? 128'hFFFF_FFFF_FFFF_FFFF : ((128'd1 << (eb*8)) - 1);
    k = 0; cyc = 0;
    while (k < n && cyc < 400) begin
      mem_ready = (($urandom % 100) < rdy_pct);
      if (poke && cyc == 0) begin
        insn_valid = 1'b1; insn = gen_insn(); base_v = $urandom; rm_v = $urandom;
      end else insn_valid = 1'b0;
      expd = (vregs[(int'(w[4:0]) + k) % 32] >> (lane*eb*8)) & mask;
      chk(mem_valid === 1'b1, "R11", "beat valid", 128'(mem_valid), 1);
      chk(mem_addr === base + 64'(k*eb), "R7", "address", 128'(mem_addr), 128'(base + 64'(k*eb)));
      chk(128'(mem_data) === expd, tag, "lane data", 128'(mem_data), expd);
      chk(mem_bytes === 4'(eb), "R6", "size", 128'(mem_bytes), 128'(eb));
      if (mem_ready) k++;
      @(negedge clk); cyc++;
    end
    insn_valid = 1'b0; mem_ready = 1'b0;
    if (k < n) chk(0, "R11", "beats missing", 128'(k), 128'(n));
    chk(!mem_valid, "R2", "extra beat", 128'(mem_valid), 0);
    if (w[23]) begin
      expw = base + ((w[20:16] == 5'd31) ? 64'(n*eb) : rmv);
      chk(wb_valid === 1'b1, "R8", "wb pulse", 128'(wb_valid), 1);
      chk(wb_data === expw, "R8", "wb value", 128'(wb_data), 128'(expw));
      chk(wb_sp === (w[9:5] == 5'd31) && wb_reg === w[9:5], "R8", "wb dest",
          128'({wb_sp, wb_reg}), 128'({w[9:5] == 5'd31, w[9:5]}));
      @(negedge clk);
    end
    chk(!wb_valid && !busy, "R8", "idle after", 128'({wb_valid, busy}), 0);
  endtask

  function automatic logic [31:0] mk(input bit q, input bit post, input bit r, input logic [4:0] rm,
                                     input logic [2:0] op, input bit s, input logic [1:0] sz,
                                     input logic [4:0] rn, input logic [4:0] rt);
    return {1'b0, q, 6'b001101, post, 1'b0, r, rm, op, s, sz, rn, rt};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    for (int i = 0; i < 32; i++) vregs[i] = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(!mem_valid && !wb_valid && !fault && !busy, "R12", "reset outputs",
        128'({mem_valid, wb_valid, fault, busy}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // byte lane 15, four regs from 30 wrapping, byte-count writeback
    run(mk(1, 1, 1, 5'd31, 3'b001, 1, 2'b11, 5'd3, 5'd30), 64'h1000, 64'h0, 100, 0, "R3");
    // halfword lane 7, register offset writeback, SP base aligned
    run(mk(1, 1, 0, 5'd7, 3'b011, 1, 2'b10, 5'd31, 5'd5), 64'h2000, 64'h40, 100, 0, "R3");
    // word lane 3 and doubleword lane 1
    run(mk(1, 0, 1, 5'd0, 3'b100, 1, 2'b00, 5'd2, 5'd9), 64'h3008, 0, 70, 0, "R4");
    run(mk(1, 1, 1, 5'd31, 3'b101, 0, 2'b01, 5'd31, 5'd31), 64'h4010, 0, 50, 1, "R4");
    // undefined forms
    run(mk(0, 0, 0, 5'd0, 3'b010, 0, 2'b01, 5'd1, 5'd1), 64'h0, 0, 100, 0, "R3");
    run(mk(0, 0, 0, 5'd0, 3'b100, 0, 2'b10, 5'd1, 5'd1), 64'h0, 0, 100, 0, "R4");
    run(mk(0, 0, 0, 5'd0, 3'b100, 1, 2'b01, 5'd1, 5'd1), 64'h0, 0, 100, 0, "R4");
    run(mk(0, 0, 0, 5'd0, 3'b110, 0, 2'b00, 5'd1, 5'd1), 64'h0, 0, 100, 0, "R5");
    run(mk(0, 0, 0, 5'd4, 3'b000, 0, 2'b00, 5'd1, 5'd1), 64'h0, 0, 100, 0, "R1");
    run(mk(0, 0, 0, 5'd0, 3'b000, 0, 2'b00, 5'd1, 5'd1) | 32'h0040_0000, 0, 0, 100, 0, "R1");
    run(mk(0, 0, 0, 5'd0, 3'b000, 0, 2'b00, 5'd1, 5'd1) ^ 32'h0100_0000, 0, 0, 100, 0, "R1");
    run(mk(0, 1, 0, 5'd3, 3'b000, 0, 2'b00, 5'd31, 5'd1), 64'h5008, 0, 100, 0, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [63:0] b;
      b = {$urandom, $urandom};
      if ($urandom % 2) b[3:0] = 4'h0;
      run(gen_insn(), b, {$urandom, $urandom}, 40 + ($urandom % 61), ($urandom % 5) == 0, "R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule